// File: doc/BRIEF.md
# Circulant block-sparse GF(2) matrix-vector multiplier

This block computes the product of a sparse binary matrix and a bit vector over GF(2). The matrix is a grid of ROWS by COLS square tiles, each P by P. A tile is either all zero or an identity matrix rotated by a shift amount. The matrix is held only as one shift code per tile. The input vector is split into COLS subvectors of P bits. The product is split into ROWS subvectors of P bits.

A start pulse launches one pass over the whole grid. The block spends one cycle on each tile. It walks the columns of a block row from left to right, and the block rows from top to bottom. In each cycle it presents the column index on a read port and takes the matching input subvector back in the same cycle. For a nonzero tile it rotates that subvector with a logarithmic barrel rotator and XORs the result into a P-bit row accumulator. A zero tile leaves the accumulator untouched. When the last column of a block row has been visited, the row sum goes out on a write port and the accumulator starts again from zero. A one-cycle done pulse closes the pass.

The shift table is a flat input vector. It is meant to be wired to a register array or ROM, and it must stay stable during a pass. Any code of P or above marks an all-zero tile. The all-ones code is the reserved value meant for this.

Top module: `circ_gf2_mul`

## Requirements
- R1: After reset, wr_en_o and done_o are low and the block is idle until a start pulse is sampled.
- R2: Take E0 as the clock edge that samples start_i high while idle. After edge E0+k, for k below ROWS*COLS, rd_addr_o equals k mod COLS. The result of block row r is written with a one-cycle wr_en_o pulse that follows edge E0+(r+1)*COLS. The rows are written in ascending order and wr_addr_o equals r.
- R3: A tile with shift code s < P contributes its input subvector rotated so that output bit b equals input bit (b+s) mod P.
- R4: Each written row value is the XOR of the contributions of all nonzero tiles in that block row. Nothing carries over from an earlier row or an earlier pass.
- R5: A tile whose shift code is P or greater contributes nothing. This includes the all-ones marker 2^SW-1. A block row made only of such tiles is written as zero.
- R6: The shift code of the tile in block row r and block column c sits at bits [(r*COLS+c)*SW +: SW] of shift_tbl_i.
- R7: done_o is high for exactly one cycle. That cycle follows edge E0+ROWS*COLS+1, which is one cycle after the last row write.
- R8: A start pulse sampled while a pass is running is ignored. The read sequence, the write timing, the write data and the done timing all stay unchanged.
- R9: A start sampled at the same edge that raises done_o begins a new pass, with E0 equal to that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a pass when sampled high while idle |
| shift_tbl_i | input | ROWS*COLS*SW | Shift code of every tile, flattened by row and then column |
| rd_addr_o | output | CW | Index of the input subvector being read |
| rd_data_i | input | P | Input subvector at rd_addr_o, valid in the same cycle |
| wr_en_o | output | 1 | Result subvector write strobe |
| wr_addr_o | output | RW | Block row of the result being written |
| wr_data_o | output | P | Result subvector |
| done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
The read index is due one clock edge after each tile visit begins. Each row write is due (r+1)*COLS edges after the start edge, and done is due ROWS*COLS+1 edges after it. The bench counts edges from the sampled start and compares every output at the falling edge after each rising edge, against a schedule and a queue of row values that it computes itself. The scenarios include passes chained through the done cycle and passes with a start pulse injected mid-pass. In those scenarios the edge counter is kept relative to the accepted start only, so a false restart shows up as a shifted write or done pulse.

// File: rtl/cmm_pkg.sv
package cmm_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cmm_state_e;
endpackage

// File: rtl/cmm_seq.sv
module cmm_seq
  import cmm_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 4,
  parameter int RW   = 2,
  parameter int CW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          last_col_o,
  output logic          done_o
);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  cmm_state_e    st_q, st_d;
  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;
  logic          fin_q, fin_d;
  logic          done_q, done_d;
  logic          last_col, last_row;

  assign last_col = (col_q == COL_LAST);
  assign last_row = (row_q == ROW_LAST);

  always_comb begin
    st_d   = st_q;
    row_d  = row_q;
    col_d  = col_q;
    fin_d  = 1'b0;
    done_d = fin_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d  = ST_RUN;
          row_d = '0;
          col_d = '0;
        end
      end
      ST_RUN: begin
        if (last_col) begin
          col_d = '0;
          if (last_row) begin
            st_d  = ST_IDLE;
            fin_d = 1'b1;
          end else begin
            row_d = row_q + 1'b1;
          end
        end else begin
          col_d = col_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      row_q  <= '0;
      col_q  <= '0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      row_q  <= row_d;
      col_q  <= col_d;
      fin_q  <= fin_d;
      done_q <= done_d;
    end
  end

  assign busy_o     = (st_q == ST_RUN);
  assign row_o      = row_q;
  assign col_o      = col_q;
  assign last_col_o = busy_o && last_col;
  assign done_o     = done_q;

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (32'(col_q) < COLS) && (32'(row_q) < ROWS)); // R2
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && last_col && !last_row) |=> (row_q == $past(row_q) + 1'b1) && (col_q == '0)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !(last_col && last_row)) |=> busy_o && ((row_q != '0) || (col_q != '0))); // R8
endmodule

// File: rtl/cmm_rot.sv
module cmm_rot #(
  parameter int P  = 8,
  parameter int SW = 8
) (
  input  logic [P-1:0]  vec_i,
  input  logic [SW-1:0] shift_i,
  output logic [P-1:0]  rot_o
);
  localparam int SLW = (P > 1) ? $clog2(P) : 1;

  logic [P-1:0] stg [SLW+1];
  logic         hit;

  assign stg[0] = vec_i;

  for (genvar j = 0; j < SLW; j++) begin : g_stage
    localparam int AMT = (2 ** j) % P;
    logic [P-1:0] moved;
    for (genvar b = 0; b < P; b++) begin : g_bit
      assign moved[b] = stg[j][(b + AMT) % P];
    end
    assign stg[j+1] = shift_i[j] ? moved : stg[j];
  end

  assign hit   = (shift_i < SW'(P));
  assign rot_o = hit ? stg[SLW] : '0;
endmodule

// File: rtl/cmm_acc.sv
module cmm_acc #(
  parameter int P  = 8,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          visit_i,
  input  logic          nz_i,
  input  logic          last_i,
  input  logic [RW-1:0] row_i,
  input  logic [P-1:0]  contrib_i,
  output logic          wr_en_o,
  output logic [RW-1:0] wr_addr_o,
  output logic [P-1:0]  wr_data_o
);
  logic [P-1:0]  acc_q, acc_d, sum;
  logic          acc_en;
  logic          wr_en_q, wr_en_d;
  logic [RW-1:0] wr_addr_q;
  logic [P-1:0]  wr_data_q;

  assign sum     = acc_q ^ contrib_i;
  assign acc_en  = clr_i || (visit_i && (nz_i || last_i));
  assign acc_d   = (clr_i || last_i) ? '0 : sum;
  assign wr_en_d = visit_i && last_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q <= 1'b0;
    end else begin
      wr_en_q <= wr_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (wr_en_d) begin
      wr_addr_q <= row_i;
      wr_data_q <= sum;
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;

  AST_ROW_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (acc_q == '0)); // R4
  AST_ZERO_TILE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (visit_i && !nz_i && !last_i && !clr_i) |=> $stable(acc_q)); // R5
endmodule

// File: rtl/circ_gf2_mul.sv
module circ_gf2_mul #(
  parameter int P    = 8,
  parameter int ROWS = 3,
  parameter int COLS = 4,
  parameter int SW   = 8,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [ROWS*COLS*SW-1:0] shift_tbl_i,
  output logic [CW-1:0]          rd_addr_o,
  input  logic [P-1:0]           rd_data_i,
  output logic                   wr_en_o,
  output logic [RW-1:0]          wr_addr_o,
  output logic [P-1:0]           wr_data_o,
  output logic                   done_o
);
  logic          busy, last_col, start_acc, nz;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [SW-1:0] cur_shift;
  logic [P-1:0]  rot;
  int unsigned   ent;

  cmm_seq #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy),
    .row_o      (row),
    .col_o      (col),
    .last_col_o (last_col),
    .done_o     (done_o)
  );

  always_comb begin
    ent       = 32'(row) * COLS + 32'(col);
    cur_shift = shift_tbl_i[ent*SW +: SW];
  end

  assign start_acc = start_i && !busy;
  assign nz        = busy && (cur_shift < SW'(P));
  assign rd_addr_o = col;

  cmm_rot #(.P(P), .SW(SW)) u_rot (
    .vec_i   (rd_data_i),
    .shift_i (cur_shift),
    .rot_o   (rot)
  );

  cmm_acc #(.P(P), .RW(RW)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (start_acc),
    .visit_i   (busy),
    .nz_i      (nz),
    .last_i    (last_col),
    .row_i     (row),
    .contrib_i (rot),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );

  AST_ROT_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    nz |-> ($countones(rot) == $countones(rd_data_i))); // R3
  AST_ZERO_CODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !nz) |-> (rot == '0)); // R5
  AST_WR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((COLS > 1) && wr_en_o) |=> !wr_en_o); // R2
endmodule

// File: tb/tb_circ_gf2_mul.sv
module tb_circ_gf2_mul;
  localparam int CLK_PERIOD = 10;
  localparam int P    = 8;
  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int SW   = 8;
  localparam int RW   = 2;
  localparam int CW   = 2;
  localparam int RC   = ROWS * COLS;

  logic                    clk;
  logic                    rst_n;
  logic                    start;
  logic [ROWS*COLS*SW-1:0] tbl;
  logic [CW-1:0]           rd_addr;
  logic [P-1:0]            rd_data;
  logic                    wr_en;
  logic [RW-1:0]           wr_addr;
  logic [P-1:0]            wr_data;
  logic                    done;
  logic [P-1:0]            vec [COLS];

  int n_tests;
  int n_fail;

  circ_gf2_mul #(.P(P), .ROWS(ROWS), .COLS(COLS), .SW(SW)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .shift_tbl_i (tbl),
    .rd_addr_o   (rd_addr),
    .rd_data_i   (rd_data),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .done_o      (done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always_comb rd_data = vec[rd_addr];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // R6: tile (r,c) code lives at bits [(r*COLS+c)*SW +: SW]
  task automatic set_ent(input int r, input int c, input int s);
    tbl[(r*COLS+c)*SW +: SW] = SW'(s);
  endtask

  task automatic fill_zero();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        set_ent(r, c, 255);
  endtask

  function automatic logic [P-1:0] ref_row(input int r);
    logic [P-1:0] a;
    int s;
    a = '0;
    for (int c = 0; c < COLS; c++) begin
      s = int'(tbl[(r*COLS+c)*SW +: SW]);
      if (s < P)
        for (int b = 0; b < P; b++)
          a[b] = a[b] ^ vec[c][(b + s) % P];
    end
    return a;
  endfunction

  task automatic run_pass(input bit own_start, input bit chain, input int dup_k,
                          input string dtag, input string stag);
    logic [P-1:0] expq [$];
    logic [P-1:0] e;
    int last_k;
    for (int r = 0; r < ROWS; r++) expq.push_back(ref_row(r));
    if (own_start) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    last_k = chain ? RC + 1 : RC + 2;
    for (int k = 1; k <= last_k; k++) begin
      @(negedge clk);
      if (k < RC)
        chk(int'(rd_addr) == (k % COLS), stag, "rd_addr", int'(rd_addr), k % COLS);
      chk(wr_en == ((k % COLS == 0) && (k <= RC)), stag, "wr_en", int'(wr_en),
          int'((k % COLS == 0) && (k <= RC)));
      if ((k % COLS == 0) && (k <= RC) && wr_en) begin
        e = expq.pop_front();
        chk(int'(wr_addr) == k / COLS - 1, stag, "wr_addr", int'(wr_addr), k / COLS - 1);
        chk(wr_data == e, dtag, "wr_data", int'(wr_data), int'(e));
      end
      chk(done == (k == RC + 1), (dup_k > 0) ? stag : "R7", "done", int'(done),
          int'(k == RC + 1));
      start = 1'b0;
      if (dup_k > 0 && k == dup_k) start = 1'b1;
      if (chain && k == RC) start = 1'b1;
    end
    start = 1'b0;
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    start   = 1'b0;
    vec[0] = 8'hA1; vec[1] = 8'h3C; vec[2] = 8'h96; vec[3] = 8'h0F;
    fill_zero();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(wr_en == 1'b0, "R1", "wr_en after reset", int'(wr_en), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(wr_en == 1'b0 && done == 1'b0, "R1", "idle without start", int'(wr_en), 0);

    // identity on the diagonal: catches a wrong table layout
    fill_zero();
    for (int r = 0; r < ROWS; r++) set_ent(r, r, 0);
    run_pass(1'b1, 1'b0, 0, "R6", "R2");

    // single rotated tiles, including the largest legal shift
    fill_zero();
    set_ent(0, 1, 1);
    set_ent(1, 3, P - 1);
    set_ent(2, 0, 3);
    vec[0] = 8'h81; vec[1] = 8'h01; vec[2] = 8'h55; vec[3] = 8'hC3;
    run_pass(1'b1, 1'b1, 0, "R3", "R2");

    // chained pass with several nonzero tiles per row
    fill_zero();
    set_ent(0, 0, 2); set_ent(0, 1, 5); set_ent(0, 2, 0);
    set_ent(1, 0, 7); set_ent(1, 1, 1); set_ent(1, 2, 4); set_ent(1, 3, 6);
    set_ent(2, 1, 0); set_ent(2, 2, 0);
    vec[0] = 8'h5A; vec[1] = 8'hE7; vec[2] = 8'h19; vec[3] = 8'hB2;
    run_pass(1'b0, 1'b0, 0, "R4", "R9");

    // only codes at or above P: every row must be zero
    fill_zero();
    set_ent(1, 2, P);
    set_ent(2, 0, 254);
    run_pass(1'b1, 1'b0, 0, "R5", "R2");

    // start pulse injected in mid-pass
    set_ent(0, 0, 2); set_ent(0, 1, 5); set_ent(0, 2, 0);
    set_ent(1, 0, 7); set_ent(1, 1, 1); set_ent(1, 2, 4); set_ent(1, 3, 6);
    set_ent(2, 1, 0); set_ent(2, 2, 0); set_ent(2, 0, 255); set_ent(1, 2, 4);
    vec[0] = 8'h33; vec[1] = 8'h80; vec[2] = 8'hFE; vec[3] = 8'h4D;
    run_pass(1'b1, 1'b0, 5, "R8", "R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("[TB] FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule